// File: doc/BRIEF.md
# Accumulation Interval Sequencer

The sequencer paces a block of sample accumulators. It counts sample-valid strobes into groups of a fixed size (42 samples by default). It then counts a host-programmed number of those groups to form one accumulation interval. At the end of each interval it emits an interval-complete strobe, which downstream logic uses to latch and restart its running sums. It also raises an active-low end-of-interval interrupt for the host.

The host sets two things: a group count and a compute-only mode bit. When compute-only is clear, a post-processing step follows each interval. In that mode the count has a floor of 24 groups, and the interrupt waits until post-processing reports done. When compute-only is set, post-processing is bypassed. Any count of one or more is accepted, and the interrupt fires at the interval end itself. A count written below the floor in normal mode is raised to the floor and sets a sticky configuration-error flag. A new setting is held back until the current interval ends, so no interval is ever cut short or stretched.

Top module: `acc_interval_seq`

## Requirements
- R1: After every 42nd sample strobe, `group_done_o` is high for exactly one cycle, in the cycle after the clock edge that sampled that strobe. No other cycle has it high.
- R2: `interval_done_o` pulses together with the `group_done_o` pulse that completes the active group count.
- R3: A write with `cfg_compute_only_i`=0 and a count below 24 is applied as 24. It also sets `cfg_err_o` from the next cycle on, and `cfg_err_o` then stays high until reset.
- R4: A write with `cfg_compute_only_i`=1 applies the count unchanged, except that 0 is applied as 1. Such a write never sets `cfg_err_o`.
- R5: A written count and mode take effect only for the interval that starts after the current interval ends. The interval in progress keeps its old count.
- R6: When an interval ends with compute-only mode active, `irq_no` goes low in the same cycle as `interval_done_o`.
- R7: When an interval ends with normal mode active, `irq_no` goes low in the cycle after the first `pp_done_i` strobe sampled after that interval end. A `pp_done_i` strobe with no finished interval pending is ignored.
- R8: Once low, `irq_no` stays low until `irq_clr_i` is sampled high. A new interrupt event at the same edge as the clear keeps it low.
- R9: After reset, all outputs are inactive (`irq_no` high, others low), counting starts from zero, and the active setting is 24 groups in normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_vld_i | input | 1 | One incoming sample per high cycle |
| cfg_we_i | input | 1 | Host write strobe for count and mode |
| cfg_cycles_i | input | CNT_W | Requested groups per interval |
| cfg_compute_only_i | input | 1 | 1 = bypass post-processing |
| irq_clr_i | input | 1 | Host clear of the interrupt |
| pp_done_i | input | 1 | Post-processing finished strobe |
| group_done_o | output | 1 | Group complete pulse |
| interval_done_o | output | 1 | Interval complete / latch strobe |
| irq_no | output | 1 | End-of-interval interrupt, active low |
| cfg_err_o | output | 1 | Sticky out-of-range configuration flag |

## Verification
The hardest case to reach is a mode change across a boundary. There, the interval that ends must follow the old mode's interrupt rule, while the next one follows the new mode. The stimulus writes a compute-only setting partway through a full-length normal interval. It then runs the rest of that interval, where the interrupt must wait for a post-processing strobe, and follows with short compute-only intervals where it must not wait. A clear is also timed to coincide with an interrupt event to exercise the set-over-clear priority. An early post-processing strobe, sent before any interval has ended, checks that such strobes are ignored.

// File: rtl/aiseq_pkg.sv
package aiseq_pkg;
  typedef enum logic {
    MODE_PP = 1'b0,
    MODE_CO = 1'b1
  } mode_e;
endpackage

// File: rtl/aiseq_grp_cnt.sv
module aiseq_grp_cnt #(
  parameter int unsigned GRP_LEN = 42
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic smp_i,
  output logic grp_end_o
);
  localparam int unsigned GRP_W = $clog2(GRP_LEN + 1);
  localparam logic [GRP_W-1:0] LAST = GRP_W'(GRP_LEN - 1);

  logic [GRP_W-1:0] cnt_q;

  assign grp_end_o = smp_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (grp_end_o) cnt_q <= '0;
    else if (smp_i)     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/aiseq_ivl_ctl.sv
module aiseq_ivl_ctl
  import aiseq_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned MIN_PP = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             grp_end_i,
  input  logic             we_i,
  input  logic [CNT_W-1:0] cyc_i,
  input  mode_e            mode_i,
  output logic             ivl_end_o,
  output logic [CNT_W-1:0] act_cyc_o,
  output mode_e            act_mode_o,
  output logic             err_o
);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_PP);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [CNT_W-1:0] eff_cyc, pend_cyc_q, act_cyc_q, cyc_cnt_q;
  mode_e            pend_mode_q, act_mode_q;
  logic             low_pp, err_q;

  // floor the request by mode
  always_comb begin
    low_pp  = 1'b0;
    eff_cyc = cyc_i;
    if (mode_i == MODE_CO) begin
      if (cyc_i == '0) eff_cyc = ONE;
    end else if (cyc_i < MIN_V) begin
      low_pp  = 1'b1;
      eff_cyc = MIN_V;
    end
  end

  assign ivl_end_o  = grp_end_i && (cyc_cnt_q == act_cyc_q - ONE);
  assign act_cyc_o  = act_cyc_q;
  assign act_mode_o = act_mode_q;
  assign err_o      = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_cyc_q  <= MIN_V;
      pend_mode_q <= MODE_PP;
      act_cyc_q   <= MIN_V;
      act_mode_q  <= MODE_PP;
      cyc_cnt_q   <= '0;
      err_q       <= 1'b0;
    end else begin
      if (we_i) begin
        pend_cyc_q  <= eff_cyc;
        pend_mode_q <= mode_i;
        if (low_pp) err_q <= 1'b1;
      end
      if (ivl_end_o) begin
        cyc_cnt_q  <= '0;
        act_cyc_q  <= pend_cyc_q;
        act_mode_q <= pend_mode_q;
      end else if (grp_end_i) begin
        cyc_cnt_q <= cyc_cnt_q + ONE;
      end
    end
  end
endmodule

// File: rtl/aiseq_irq.sv
module aiseq_irq
  import aiseq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  ivl_end_i,
  input  mode_e act_mode_i,
  input  logic  pp_done_i,
  input  logic  clr_i,
  output logic  irq_no
);
  logic wait_q, irq_q, set;

  assign set    = (ivl_end_i && act_mode_i == MODE_CO) || (wait_q && pp_done_i);
  assign irq_no = !irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wait_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (ivl_end_i && act_mode_i == MODE_PP) wait_q <= 1'b1;
      else if (wait_q && pp_done_i)           wait_q <= 1'b0;
      if (set)        irq_q <= 1'b1;
      else if (clr_i) irq_q <= 1'b0;
    end
  end
endmodule

// File: rtl/acc_interval_seq.sv
module acc_interval_seq
  import aiseq_pkg::*;
#(
  parameter int unsigned GRP_LEN = 42,
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned MIN_PP  = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_vld_i,
  input  logic             cfg_we_i,
  input  logic [CNT_W-1:0] cfg_cycles_i,
  input  logic             cfg_compute_only_i,
  input  logic             irq_clr_i,
  input  logic             pp_done_i,
  output logic             group_done_o,
  output logic             interval_done_o,
  output logic             irq_no,
  output logic             cfg_err_o
);
  logic             grp_end, ivl_end;
  logic [CNT_W-1:0] act_cyc;
  mode_e            act_mode;

  aiseq_grp_cnt #(.GRP_LEN(GRP_LEN)) u_grp (
    .clk_i, .rst_ni, .smp_i(sample_vld_i), .grp_end_o(grp_end)
  );

  aiseq_ivl_ctl #(.CNT_W(CNT_W), .MIN_PP(MIN_PP)) u_ivl (
    .clk_i, .rst_ni,
    .grp_end_i (grp_end),
    .we_i      (cfg_we_i),
    .cyc_i     (cfg_cycles_i),
    .mode_i    (mode_e'(cfg_compute_only_i)),
    .ivl_end_o (ivl_end),
    .act_cyc_o (act_cyc),
    .act_mode_o(act_mode),
    .err_o     (cfg_err_o)
  );

  aiseq_irq u_irq (
    .clk_i, .rst_ni,
    .ivl_end_i (ivl_end),
    .act_mode_i(act_mode),
    .pp_done_i,
    .clr_i     (irq_clr_i),
    .irq_no
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      group_done_o    <= 1'b0;
      interval_done_o <= 1'b0;
    end else begin
      group_done_o    <= grp_end;
      interval_done_o <= ivl_end;
    end
  end
endmodule

// File: rtl/aiseq_chk.sv
module aiseq_chk #(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned MIN_PP = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pp_done_i,
  input logic             irq_clr_i,
  input logic             group_done_o,
  input logic             interval_done_o,
  input logic             irq_no,
  input logic             cfg_err_o,
  input logic             ivl_end,
  input logic [CNT_W-1:0] act_cyc,
  input logic             act_mode
);
  // R1
  grp_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    group_done_o |=> !group_done_o);
  // R2
  ivl_on_grp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    interval_done_o |-> group_done_o);
  // R3
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> cfg_err_o);
  // R3
  pp_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_mode |-> act_cyc >= CNT_W'(MIN_PP));
  // R4
  cnt_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_cyc != '0);
  // R5
  load_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_cyc) |-> interval_done_o);
  // R6
  co_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ivl_end && act_mode) |=> !irq_no);
  // R7
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_no) |-> (interval_done_o || $past(pp_done_i)));
  // R8
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_no && !irq_clr_i) |=> !irq_no);
endmodule

bind acc_interval_seq aiseq_chk #(.CNT_W(CNT_W), .MIN_PP(MIN_PP)) chk_i (
  .clk_i, .rst_ni, .pp_done_i, .irq_clr_i, .group_done_o, .interval_done_o,
  .irq_no, .cfg_err_o, .ivl_end, .act_cyc, .act_mode(act_mode)
);

// File: tb/acc_interval_seq_tb_top.sv
module acc_interval_seq_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       vld = 0, we = 0, co = 0, clr = 0, pp = 0;
  logic [7:0] cyc = '0;
  logic       grp_o, ivl_o, irq_n_o, err_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  acc_interval_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sample_vld_i(vld), .cfg_we_i(we),
    .cfg_cycles_i(cyc), .cfg_compute_only_i(co), .irq_clr_i(clr),
    .pp_done_i(pp), .group_done_o(grp_o), .interval_done_o(ivl_o),
    .irq_no(irq_n_o), .cfg_err_o(err_o)
  );

  typedef struct {
    logic  grp, ivl, irq_n, err;
    string tag;
  } exp_t;
  exp_t q[$];

  // requirement-level model state
  int m_scnt = 0, m_ccnt = 0, m_act = 24, m_pend = 24;
  bit m_act_co = 0, m_pend_co = 0, m_wait = 0, m_irq = 0, m_err = 0;

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic w, input logic [7:0] c, input logic m,
                      input logic cl, input logic p, input string tag);
    bit g, iv, set;
    int eff;
    exp_t e;
    @(negedge clk);
    vld = v; we = w; cyc = c; co = m; clr = cl; pp = p;
    g   = v && (m_scnt == 41);
    iv  = g && (m_ccnt == m_act - 1);
    set = (iv && m_act_co) || (m_wait && p);
    if (iv && !m_act_co) m_wait = 1;
    else if (m_wait && p) m_wait = 0;
    if (set) m_irq = 1; else if (cl) m_irq = 0;
    if (v) m_scnt = g ? 0 : m_scnt + 1;
    if (g) m_ccnt = iv ? 0 : m_ccnt + 1;
    if (iv) begin m_act = m_pend; m_act_co = m_pend_co; end
    if (w) begin
      if (m) eff = (c == 0) ? 1 : int'(c);
      else   eff = (c < 24) ? 24 : int'(c);
      if (!m && c < 24) m_err = 1;
      m_pend = eff; m_pend_co = m;
    end
    e.grp = g; e.ivl = iv; e.irq_n = !m_irq; e.err = m_err; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic samples(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic samples_gap(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      step(1, 0, 0, 0, 0, 0, tag);
      if (i % 3 == 0) step(0, 0, 0, 0, 0, 0, tag);
    end
  endtask
  task automatic write_cfg(input logic [7:0] c, input logic m, input string tag);
    step(0, 1, c, m, 0, 0, tag);
  endtask
  task automatic pulse_pp(input string tag);
    step(0, 0, 0, 0, 0, 1, tag);
  endtask
  task automatic clear(input string tag);
    step(0, 0, 0, 0, 1, 0, tag);
  endtask

  // monitor: pop and compare one item per driven cycle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, "/R1"}, "group_done", grp_o, e.grp);
        chk({e.tag, "/R2"}, "interval_done", ivl_o, e.ivl);
        chk({e.tag, "/R8"}, "irq_n", irq_n_o, e.irq_n);
        chk({e.tag, "/R3"}, "cfg_err", err_o, e.err);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9", "group_done", grp_o, 1'b0);
    chk("R9", "interval_done", ivl_o, 1'b0);
    chk("R9", "irq_n", irq_n_o, 1'b1);
    chk("R9", "cfg_err", err_o, 1'b0);
    rst_n = 1'b1;
    idle(2, "R9");
    samples(100, "R1");
    pulse_pp("R7");            // no finished interval: ignored
    write_cfg(8'd0, 1'b1, "R4"); // compute-only, 0 -> 1
    samples(908, "R5");        // old 24-group interval still runs
    idle(3, "R7");
    pulse_pp("R7");
    idle(2, "R7");
    samples(42, "R6");         // one-group compute-only interval
    clear("R8");
    idle(3, "R8");
    samples(42, "R6");
    clear("R8");
    samples(41, "R8");
    step(1, 0, 0, 0, 1, 0, "R8"); // clear and set together: stays low
    idle(2, "R8");
    clear("R8");
    write_cfg(8'd5, 1'b0, "R3"); // below floor: 24 and error
    idle(2, "R3");
    samples_gap(42, "R5");      // last compute-only interval
    clear("R6");
    samples_gap(500, "R3");
    write_cfg(8'd3, 1'b1, "R4");
    samples_gap(508, "R2");
    idle(2, "R7");
    pulse_pp("R7");
    clear("R8");
    samples(126, "R4");         // three groups
    clear("R8");
    write_cfg(8'd30, 1'b0, "R3"); // in range: error stays sticky
    samples(126, "R4");
    idle(4, "R3");
    while (q.size() > 0) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule